// File: doc/BRIEF.md
# Reloading Timer Bank with Free-Running Counter

This block holds three down-counting timer channels, two 16 bits wide and one 32 bits wide, and one 40-bit up-counter that runs freely and raises no interrupt. All of them sit behind one single-cycle register port. A write takes effect at the clock edge when `we` is high. A read returns data combinationally for the address currently driven. The counters do not divide a clock. They advance on enable pulses: `tick_fast` and `tick_slow` feed the down-counters and `tick_free` feeds the up-counter.

Software sets a channel up in three steps. It first writes the mode and tick-select bits with the enable bit low, then writes the start value, and then sets enable. An enabled channel counts one step on each pulse of the tick it has selected. When it steps down from zero it raises its interrupt and either reloads its start value or wraps to its all-ones value. The interrupt is a level. It stays high until software writes to the channel's clear register.

Top module: `tmr_bank`

## Requirements
- R1: The three channels decode at base addresses 0x00, 0x20 and 0x80 (16, 16 and 32 bits wide). Within a base, the start value is at +0x0, the current count at +0x4, control at +0x8 and interrupt clear at +0xC. The start value reads back as written, and the clear register reads as zero.
- R2: Control bit 7 enables counting, bit 6 selects reload mode and bit 3 selects `tick_fast` (clear selects `tick_slow`). A control read returns only these three bits; all other bits read zero.
- R3: An enabled channel decrements by exactly one per pulse of its selected tick. Pulses on the unselected tick, and any pulse while enable is low, leave the count unchanged.
- R4: In reload mode, a tick that arrives while the count is zero loads the start value into the count and sets the channel's interrupt output (`irq[0]`, `irq[1]`, `irq[2]` for the channels at 0x00, 0x20, 0x80).
- R5: With reload mode clear, a tick at count zero wraps the count to all ones (0xFFFF for a 16-bit channel, 0xFFFFFFFF for the 32-bit one) and sets the interrupt.
- R6: An interrupt stays high through further ticks until any value is written to that channel's clear register. A clear write in the same cycle as a new underflow leaves it high.
- R7: Writing the start value copies it into the count in the same edge, whether or not the channel is enabled. The next tick counts down from that value.
- R8: The 40-bit counter increments by one on each `tick_free` pulse while its enable (bit 8 at 0x64) is set. It holds while the enable is clear, and it comes out of reset at zero and disabled.
- R9: Address 0x60 reads counter bits 31:0. Address 0x64 reads counter bits 39:32 in bits 7:0 and the enable in bit 8. A write to 0x60 is ignored, and a write to 0x64 changes only the enable.
- R10: After reset every count, start value, control field and interrupt is zero. Addresses not mapped to a register read zero.
- R11: A 16-bit channel keeps only the low 16 bits of a written start value, and its count and start value read with bits 31:16 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| we | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tick_fast | input | 1 | Fast-rate step pulse for the down-counters |
| tick_slow | input | 1 | Slow-rate step pulse for the down-counters |
| tick_free | input | 1 | Step pulse for the 40-bit up-counter |
| irq | output | 3 | Interrupt levels, one per channel |

## Verification
The hardest case to reach is a clear write that lands on the same edge as a fresh underflow. To hit it, the stimulus parks a reload-mode channel with a start value of zero, so every selected tick underflows. It then drives the clear write and a fast tick on the same falling edge and checks that the interrupt is still high one edge later. The 40-bit counter cannot be pushed across its 32-bit boundary in a short run. The stimulus therefore checks the high word's layout and the enable-only effect of high-word writes while the counter holds a small known count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int NUM_CH = 3;
   localparam int CH_W [NUM_CH] = '{16, 16, 32};
   localparam logic [7:0] CH_BASE [NUM_CH] = '{8'h00, 8'h20, 8'h80};

   localparam logic [1:0] REG_LOAD = 2'd0;
   localparam logic [1:0] REG_CNT  = 2'd1;
   localparam logic [1:0] REG_CTRL = 2'd2;
   localparam logic [1:0] REG_CLR  = 2'd3;

   localparam int BIT_EN      = 7;
   localparam int BIT_RELOAD  = 6;
   localparam int BIT_FAST    = 3;
   localparam int BIT_FREE_EN = 8;

   localparam logic [7:0] FREE_LO = 8'h60;
   localparam logic [7:0] FREE_HI = 8'h64;

   typedef struct packed {
      logic en;
      logic reload;
      logic fast;
   } ctrl_t;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  logic [1:0]        idx,
   input  logic [CNT_W-1:0]  wdata,
   input  logic              tick_fast,
   input  logic              tick_slow,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   if (CNT_W < BIT_EN + 1 || CNT_W > DATA_W) begin : g_bad_width
      $error("tmr_chan: CNT_W must lie between %0d and DATA_W", BIT_EN + 1);
   end

   logic [CNT_W-1:0] load_q, cnt_q;
   ctrl_t            ctrl_q;
   logic             irq_q;
   logic             wr_load, wr_ctrl, wr_clr, tick, step, under;

   assign wr_load = sel && we && (idx == REG_LOAD);
   assign wr_ctrl = sel && we && (idx == REG_CTRL);
   assign wr_clr  = sel && we && (idx == REG_CLR);
   assign tick    = ctrl_q.fast ? tick_fast : tick_slow;
   assign step    = ctrl_q.en && tick && !wr_load;
   assign under   = step && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         cnt_q  <= '0;
      end else if (wr_load) begin
         load_q <= wdata;
         cnt_q  <= wdata;
      end else if (step) begin
         if (under) cnt_q <= ctrl_q.reload ? load_q : '1;
         else       cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= '{en: wdata[BIT_EN], reload: wdata[BIT_RELOAD],
                                    fast: wdata[BIT_FAST]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      irq_q <= 1'b0;
      else if (under)  irq_q <= 1'b1;
      else if (wr_clr) irq_q <= 1'b0;
   end

   assign irq = irq_q;

   always_comb begin
      rdata = '0;
      if (sel) begin
         case (idx)
            REG_LOAD: rdata = DATA_W'(load_q);
            REG_CNT:  rdata = DATA_W'(cnt_q);
            REG_CTRL: begin
               rdata[BIT_EN]     = ctrl_q.en;
               rdata[BIT_RELOAD] = ctrl_q.reload;
               rdata[BIT_FAST]   = ctrl_q.fast;
            end
            default:  rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/tmr_free.sv
module tmr_free
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 40,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_lo,
   input  logic              sel_hi,
   input  logic              we,
   input  logic              wr_en_bit,
   input  logic              tick,
   output logic [DATA_W-1:0] rdata,
   output logic              en,
   output logic [CNT_W-1:0]  cnt
);
   localparam int HI_W = CNT_W - DATA_W;

   if (HI_W < 1 || HI_W > BIT_FREE_EN) begin : g_bad_width
      $error("tmr_free: upper part must be 1 to %0d bits", BIT_FREE_EN);
   end

   logic [CNT_W-1:0]  cnt_q;
   logic              en_q;
   logic [DATA_W-1:0] hi_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             en_q <= 1'b0;
      else if (sel_hi && we)  en_q <= wr_en_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (en_q && tick) cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      hi_word              = '0;
      hi_word[HI_W-1:0]    = cnt_q[CNT_W-1:DATA_W];
      hi_word[BIT_FREE_EN] = en_q;
   end

   assign rdata = sel_lo ? cnt_q[DATA_W-1:0] : (sel_hi ? hi_word : '0);
   assign en    = en_q;
   assign cnt   = cnt_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int FREE_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tick_fast,
   input  logic              tick_slow,
   input  logic              tick_free,
   output logic [NUM_CH-1:0] irq
);
   if (ADDR_W != 8 || DATA_W != 32) begin : g_bad_bus
      $error("tmr_bank: register map needs an 8-bit address and 32-bit data");
   end

   logic [DATA_W-1:0] rd_ch [NUM_CH];
   logic [DATA_W-1:0] rd_free;
   logic              free_en;
   logic [FREE_W-1:0] free_cnt;
   logic              word_ok;

   assign word_ok = (addr[1:0] == 2'b00);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam int W = CH_W[g];
      logic sel;
      assign sel = word_ok && (addr[7:4] == CH_BASE[g][7:4]);

      tmr_chan #(.CNT_W(W), .DATA_W(DATA_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel       (sel),
         .we        (we),
         .idx       (addr[3:2]),
         .wdata     (wdata[W-1:0]),
         .tick_fast (tick_fast),
         .tick_slow (tick_slow),
         .rdata     (rd_ch[g]),
         .irq       (irq[g])
      );
   end

   tmr_free #(.CNT_W(FREE_W), .DATA_W(DATA_W)) u_free (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_lo    (addr == FREE_LO),
      .sel_hi    (addr == FREE_HI),
      .we        (we),
      .wr_en_bit (wdata[BIT_FREE_EN]),
      .tick      (tick_free),
      .rdata     (rd_free),
      .en        (free_en),
      .cnt       (free_cnt)
   );

   always_comb begin
      rdata = rd_free;
      for (int i = 0; i < NUM_CH; i++) rdata = rdata | rd_ch[i];
   end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
   import tmr_pkg::*;
#(
   parameter int FREE_W = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [7:0]        addr,
   input logic              tick_fast,
   input logic              tick_slow,
   input logic              tick_free,
   input logic [NUM_CH-1:0] irq,
   input logic              free_en,
   input logic [FREE_W-1:0] free_cnt
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_irq
      localparam logic [7:0] CLR_ADDR = CH_BASE[g] + 8'h0C;

      AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq[g]) |-> $past(we && addr == CLR_ADDR)); // R6

      AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[g]) |-> $past(tick_fast || tick_slow)); // R4
   end

   AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(free_en && tick_free) |-> free_cnt == $past(free_cnt) + 1'b1); // R8

   AST_FREE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(free_en && tick_free) |-> $stable(free_cnt)); // R8
endmodule

bind tmr_bank tmr_bank_chk #(.FREE_W(FREE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .we        (we),
   .addr      (addr),
   .tick_fast (tick_fast),
   .tick_slow (tick_slow),
   .tick_free (tick_free),
   .irq       (irq),
   .free_en   (free_en),
   .free_cnt  (free_cnt)
);

// File: tb/tmr_bank_test.sv
module tmr_bank_test;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic        wr;
      logic [7:0]  a;
      logic [31:0] d;
   } vec_t;

   // Map and control-field vectors: write (wr=1) or read-and-compare (wr=0).
   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h00, 32'h0000ABCD}, // R1 channel 1 start value
      '{1'b0, 8'h00, 32'h0000ABCD}, // R1
      '{1'b1, 8'h20, 32'h12345678}, // R11 truncated to 16 bits
      '{1'b0, 8'h20, 32'h00005678}, // R11
      '{1'b0, 8'h24, 32'h00005678}, // R7 count follows start value
      '{1'b1, 8'h80, 32'hDEADBEEF}, // R1 32-bit channel
      '{1'b0, 8'h80, 32'hDEADBEEF}, // R1
      '{1'b0, 8'h84, 32'hDEADBEEF}, // R7
      '{1'b1, 8'h08, 32'hFFFFFFFF}, // R2 all bits written
      '{1'b0, 8'h08, 32'h000000C8}, // R2 only bits 7,6,3 kept
      '{1'b1, 8'h08, 32'h00000000}, // R2
      '{1'b0, 8'h40, 32'h00000000}, // R10 unmapped address
      '{1'b0, 8'h0C, 32'h00000000}  // R1 clear register reads zero
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tick_fast = 1'b0, tick_slow = 1'b0, tick_free = 1'b0;
   logic [2:0]  irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   tmr_bank uut (
      .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tick_fast(tick_fast), .tick_slow(tick_slow),
      .tick_free(tick_free), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic pulse(input logic f, input logic s, input logic fr);
      @(negedge clk);
      tick_fast = f; tick_slow = s; tick_free = fr;
      @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0; tick_free = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      do_reset();

      // R10 reset state
      check("R10 irq", {29'd0, irq}, 32'd0);
      rd(8'h04, v); check("R10 ch1 count", v, 32'd0);
      rd(8'h88, v); check("R10 ch3 ctrl", v, 32'd0);
      rd(8'h60, v); check("R10/R8 free lo", v, 32'd0);
      rd(8'h64, v); check("R10/R8 free hi", v, 32'd0);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
         else begin
            rd(VEC[i].a, v);
            check($sformatf("R1/R2/R7/R10/R11 vector %0d", i), v, VEC[i].d);
         end
      end

      // Channel 1: reload mode, fast tick
      do_reset();
      wr(8'h08, 32'h48);
      wr(8'h00, 32'd3);
      wr(8'h08, 32'hC8);
      pulse(1, 0, 0);
      rd(8'h04, v); check("R3 fast step", v, 32'd2);
      pulse(0, 1, 0);
      rd(8'h04, v); check("R3 unselected tick", v, 32'd2);
      pulse(1, 0, 0);
      pulse(1, 0, 0);
      rd(8'h04, v); check("R3 reach zero", v, 32'd0);
      check("R4 no irq yet", {31'd0, irq[0]}, 32'd0);
      pulse(1, 0, 0);
      rd(8'h04, v); check("R4 reload", v, 32'd3);
      check("R4 irq set", {31'd0, irq[0]}, 32'd1);
      pulse(1, 0, 0);
      check("R6 irq held", {31'd0, irq[0]}, 32'd1);
      wr(8'h0C, 32'h0);
      check("R6 irq cleared", {31'd0, irq[0]}, 32'd0);

      // R6 clear on the same edge as a new underflow
      wr(8'h00, 32'd0);
      @(negedge clk);
      addr = 8'h0C; wdata = 32'h5A; we = 1'b1; tick_fast = 1'b1;
      @(negedge clk);
      we = 1'b0; tick_fast = 1'b0;
      check("R6 clear vs underflow", {31'd0, irq[0]}, 32'd1);
      wr(8'h0C, 32'h0);
      check("R6 later clear", {31'd0, irq[0]}, 32'd0);

      // Channel 2: one-shot wrap on slow tick
      wr(8'h28, 32'h00);
      wr(8'h20, 32'd1);
      pulse(0, 1, 0);
      rd(8'h24, v); check("R3 disabled hold", v, 32'd1);
      wr(8'h28, 32'h80);
      pulse(0, 1, 0);
      rd(8'h24, v); check("R3 slow step", v, 32'd0);
      pulse(0, 1, 0);
      rd(8'h24, v); check("R5 wrap 16-bit", v, 32'h0000FFFF);
      check("R5 irq ch2", {31'd0, irq[1]}, 32'd1);
      pulse(1, 0, 0);
      rd(8'h24, v); check("R3 fast ignored on slow channel", v, 32'h0000FFFF);

      // Channel 3: 32-bit wrap and load while enabled
      wr(8'h80, 32'd0);
      wr(8'h88, 32'h88);
      pulse(1, 0, 0);
      rd(8'h84, v); check("R5 wrap 32-bit", v, 32'hFFFFFFFF);
      check("R5 irq ch3", {31'd0, irq[2]}, 32'd1);
      wr(8'h80, 32'h10);
      rd(8'h84, v); check("R7 load while enabled", v, 32'h10);
      pulse(1, 0, 0);
      rd(8'h84, v); check("R7 count from new value", v, 32'h0F);

      // 40-bit free counter
      pulse(0, 0, 1);
      rd(8'h60, v); check("R8 disabled hold", v, 32'd0);
      wr(8'h64, 32'h100);
      for (int k = 0; k < 3; k++) pulse(0, 0, 1);
      rd(8'h60, v); check("R8 count", v, 32'd3);
      rd(8'h64, v); check("R9 high word", v, 32'h100);
      wr(8'h60, 32'hABC);
      rd(8'h60, v); check("R9 low write ignored", v, 32'd3);
      wr(8'h64, 32'h0FF);
      rd(8'h64, v); check("R9 high write only enable", v, 32'h000);
      rd(8'h60, v); check("R9 count untouched", v, 32'd3);
      pulse(0, 0, 1);
      rd(8'h60, v); check("R8 stop after disable", v, 32'd3);

      finish_run();
   end
endmodule